// File: doc/BRIEF.md
# Stall-Watermark Output FIFO

This block is a synchronous FIFO that sits behind the last stage of a deep pipeline. It reports full and empty as usual. It also raises a watermark flag while only a small, parameterised number of free entries remains. That flag is inverted and sent through a short chain of registers that the enable path owns. The chain is built several times over, so every copy of the pipeline enable output drives only part of the upstream load and no single combinational net reaches every stage.

The watermark margin must be at least the depth of the enable chain plus one. A word that is still in flight when the watermark rises can then be written before the delayed enable freezes the pipeline, and it finds a free slot. A write attempted while the FIFO is full is dropped and reported on a registered error flag. In a correctly sized system that flag never rises.

Top module: `stall_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, occupancy is 0, empty is 1, full, almostFull and overflow are 0, and every pipeEn copy is 1.
- R2: Words are read out in the order they were accepted, and rdData always shows the oldest stored word while empty is 0 (first-word fall-through).
- R3: Occupancy rises by one after a cycle with an accepted write and no accepted read. It falls by one after an accepted read with no accepted write. It is unchanged when both or neither are accepted. empty is high exactly at occupancy 0 and full exactly at occupancy DEPTH.
- R4: With HYST = 0, almostFull is high exactly while occupancy is at least DEPTH - MARGIN (12 with the defaults).
- R5: Each pipeEn copy equals the inverse of almostFull delayed by EN_LEVELS clock cycles (2 by default). Its value is 1 for the cycles whose history reaches back into reset.
- R6: All EN_COPIES pipeEn copies carry the same value in every cycle.
- R7: A write while full is dropped, even when a read happens in the same cycle, and leaves occupancy and contents unchanged. overflow is high in the cycle after such an attempt and low otherwise. A read while empty has no effect and occupancy stays 0.
- R8: When the upstream pipeline advances only while pipeEn is 1, occupancy never exceeds DEPTH - MARGIN + EN_LEVELS (14 by default). No write is then refused and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request from the last pipeline stage |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read request from the consumer |
| rdData | output | DATA_W | Oldest stored word |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| almostFull | output | 1 | Watermark: free entries at or below MARGIN |
| overflow | output | 1 | A write was attempted while full in the previous cycle |
| occupancy | output | $clog2(DEPTH+1) | Number of stored words |
| pipeEn | output | EN_COPIES | Replicated, registered enable for the upstream pipeline |

## Verification
The overflow and hold properties assume that wrEn and rdEn are driven to known values in every cycle and stay low during reset. The bench drives them at the falling edge and clears them while reset is held. The flow-control bound of R8 holds only when the producer honours pipeEn. In the closed-loop phase the bench's pipeline model therefore advances, and writes, only in cycles where the sampled enable copy is 1, and it keeps a valid word in its last stage. The open-loop sweeps ignore the enable on purpose so that writes to a full FIFO and reads from an empty one can be reached.

// File: rtl/stall_fifo_pkg.sv
package stall_fifo_pkg;
  // Strobes passed from the control module to the storage datapath
  typedef struct packed {
    logic wrDo;
    logic rdDo;
  } fifoStrobes_t;
endpackage

// File: rtl/stall_fifo_ctrl.sv
module stall_fifo_ctrl
  import stall_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int MARGIN = 4,
  parameter int HYST   = 0,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  output fifoStrobes_t     strb,
  output logic [CNT_W-1:0] occupancy,
  output logic             empty,
  output logic             full,
  output logic             almostFull,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] SET_CNT  = CNT_W'(DEPTH - MARGIN);
  localparam logic [CNT_W-1:0] CLR_CNT  = CNT_W'(DEPTH - MARGIN - HYST);

  logic [CNT_W-1:0] cnt, cntNext;
  logic             afReg, afNext;

  always_comb begin
    strb.wrDo = wrEn && (cnt != FULL_CNT);
    strb.rdDo = rdEn && (cnt != '0);
    case ({strb.wrDo, strb.rdDo})
      2'b10:   cntNext = cnt + 1'b1;
      2'b01:   cntNext = cnt - 1'b1;
      default: cntNext = cnt;
    endcase
    // Set at the watermark; with hysteresis, hold until below the lower level
    afNext = (cntNext >= SET_CNT) ||
             ((HYST != 0) && afReg && (cntNext >= CLR_CNT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      afReg    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      cnt      <= cntNext;
      afReg    <= afNext;
      overflow <= wrEn && (cnt == FULL_CNT);
    end
  end

  assign occupancy  = cnt;
  assign empty      = (cnt == '0);
  assign full       = (cnt == FULL_CNT);
  assign almostFull = afReg;
endmodule

// File: rtl/stall_fifo_dp.sv
module stall_fifo_dp
  import stall_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrDo) wrPtr <= bump(wrPtr);
      if (strb.rdDo) rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrDo) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/stall_fifo_enpipe.sv
module stall_fifo_enpipe #(
  parameter int LEVELS = 2,
  parameter int COPIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stallReq,
  output logic [COPIES-1:0] pipeEn
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [LEVELS-1:0] chain;
    if (LEVELS == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= ~stallReq;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[LEVELS-2:0], ~stallReq};
      end
    end
    assign pipeEn[c] = chain[LEVELS-1];
  end
endmodule

// File: rtl/stall_fifo.sv
module stall_fifo
  import stall_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int MARGIN    = 4,
  parameter int HYST      = 0,
  parameter int EN_LEVELS = 2,
  parameter int EN_COPIES = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 empty,
  output logic                 full,
  output logic                 almostFull,
  output logic                 overflow,
  output logic [CNT_W-1:0]     occupancy,
  output logic [EN_COPIES-1:0] pipeEn
);
  fifoStrobes_t strb;

  stall_fifo_ctrl #(.DEPTH(DEPTH), .MARGIN(MARGIN), .HYST(HYST), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .strb(strb),
    .occupancy(occupancy), .empty(empty), .full(full),
    .almostFull(almostFull), .overflow(overflow)
  );

  stall_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );

  stall_fifo_enpipe #(.LEVELS(EN_LEVELS), .COPIES(EN_COPIES)) i_en (
    .clk(clk), .rstN(rstN), .stallReq(almostFull), .pipeEn(pipeEn)
  );
endmodule

// File: rtl/stall_fifo_chk.sv
module stall_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int MARGIN    = 4,
  parameter int HYST      = 0,
  parameter int EN_COPIES = 4,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic                 empty,
  input logic                 full,
  input logic                 almostFull,
  input logic                 overflow,
  input logic [CNT_W-1:0]     occupancy,
  input logic [EN_COPIES-1:0] pipeEn
);
  localparam logic [CNT_W-1:0] SET_CNT = CNT_W'(DEPTH - MARGIN);

  logic wrOk, rdOk;
  assign wrOk = wrEn && !full;
  assign rdOk = rdEn && !empty;

  // R3
  occ_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && !rdOk) |=> (occupancy == $past(occupancy) + 1'b1));
  // R3
  occ_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdOk && !wrOk) |=> (occupancy == $past(occupancy) - 1'b1));
  // R3
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk == rdOk) |=> $stable(occupancy));
  // R4
  watermark_chk: assert property (@(posedge clk) disable iff (!rstN || HYST != 0)
    almostFull == (occupancy >= SET_CNT));
  // R6
  copies_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipeEn == {EN_COPIES{pipeEn[0]}});
  // R7
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full) |=> overflow);
  // R7
  overflow_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && full) |=> !overflow);
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !rdEn) |=> full);
endmodule

bind stall_fifo stall_fifo_chk #(
  .DEPTH(DEPTH), .MARGIN(MARGIN), .HYST(HYST), .EN_COPIES(EN_COPIES)
) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .empty(empty), .full(full),
  .almostFull(almostFull), .overflow(overflow), .occupancy(occupancy), .pipeEn(pipeEn)
);

// File: tb/test_stall_fifo.sv
module test_stall_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int MARG  = 4;
  localparam int LV    = 2;
  localparam int NC    = 4;
  localparam int THR   = DEPTH - MARG;
  localparam int STAGES = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic empty, full, almostFull, overflow;
  logic [4:0] occupancy;
  logic [NC-1:0] pipeEn;

  always #10 clk = ~clk;

  stall_fifo i_stall_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .empty(empty), .full(full), .almostFull(almostFull),
    .overflow(overflow), .occupancy(occupancy), .pipeEn(pipeEn)
  );

  int vectors = 0, misses = 0;
  bit done = 1'b0;

  // reference model
  int mq [DEPTH];
  int mHead = 0, mTail = 0, mCnt = 0;
  bit expOvf = 1'b0;
  bit e0 = 1'b1, e1 = 1'b1;
  int peak = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R3 occupancy", int'(occupancy), mCnt);
    chk("R3 empty", int'(empty), int'(mCnt == 0));
    chk("R3 full", int'(full), int'(mCnt == DEPTH));
    chk("R4 almostFull", int'(almostFull), int'(mCnt >= THR));
    chk("R7 overflow", int'(overflow), int'(expOvf));
    chk("R5 pipeEn[0]", int'(pipeEn[0]), int'(e1));
    chk("R6 copies", int'(pipeEn), e1 ? (1 << NC) - 1 : 0);
    if (mCnt > 0) chk("R2 rdData", int'(rdData), mq[mHead]);
  endtask

  // called just after a falling edge; returns after the next falling edge
  task automatic doCycle(input bit w, input int d, input bit r);
    bit accW, accR, afBefore;
    wrEn = w; wrData = DW'(d); rdEn = r;
    accW = w && (mCnt < DEPTH);
    accR = r && (mCnt > 0);
    afBefore = (mCnt >= THR);
    @(posedge clk);
    expOvf = w && (mCnt == DEPTH);
    e1 = e0;
    e0 = !afBefore;
    if (accR) mHead = (mHead + 1) % DEPTH;
    if (accW) begin
      mq[mTail] = d;
      mTail = (mTail + 1) % DEPTH;
    end
    mCnt = mCnt + int'(accW) - int'(accR);
    if (mCnt > peak) peak = mCnt;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int vld [STAGES];
    int dat [STAGES];
    int src;
    bit en;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: values while reset is still held
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 almostFull", int'(almostFull), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 pipeEn", int'(pipeEn), (1 << NC) - 1);
    rstN = 1'b1;
    // R1: first cycle out of reset, nothing requested
    doCycle(0, 0, 0);

    // R7: read on empty has no effect
    doCycle(0, 0, 1);
    doCycle(0, 0, 1);
    // fill to full, then write past it (R7), including with a read request
    for (int i = 0; i < DEPTH; i++) doCycle(1, 8'h40 + i, 0);
    doCycle(1, 8'hEE, 0);
    doCycle(1, 8'hEF, 0);
    doCycle(1, 8'hF0, 1);
    // R3: simultaneous read and write keep occupancy
    for (int i = 0; i < 6; i++) doCycle(1, 8'h90 + i, 1);
    // drain and read past empty (R2, R7)
    for (int i = 0; i < DEPTH + 3; i++) doCycle(0, 0, 1);

    // near-exhaustive density sweep, enable ignored on purpose
    for (int wd = 0; wd < 4; wd++)
      for (int rd = 0; rd < 4; rd++)
        for (int k = 0; k < 200; k++)
          doCycle($urandom_range(3) <= wd, $urandom_range(255), $urandom_range(3) <= rd);
    for (int i = 0; i < DEPTH + 2; i++) doCycle(0, 0, 1);

    // R8: closed loop, upstream pipeline honours pipeEn
    src = 0;
    peak = 0;
    for (int s = 0; s < STAGES; s++) begin
      vld[s] = 1;
      dat[s] = src;
      src = (src + 1) % 256;
    end
    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit r;
      en = pipeEn[0];
      r = ((cyc / 41) % 3) == 0 || ((cyc % 7) == 0);
      doCycle(en && (vld[STAGES-1] != 0), dat[STAGES-1], r);
      chk("R8 no refused write", int'(overflow), 0);
      if (en) begin
        for (int s = STAGES - 1; s > 0; s--) begin
          vld[s] = vld[s-1];
          dat[s] = dat[s-1];
        end
        vld[0] = 1;
        dat[0] = src;
        src = (src + 1) % 256;
      end
    end
    chk("R8 peak bound", int'(peak <= THR + LV), 1);
    chk("R8 watermark reached", int'(peak >= THR), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule